// File: doc/BRIEF.md
# Frame-Aligned Slot Memory with Counter and Random Addressing

This block is a single-port store of 2048 sixteen-bit words for time-slot switching. On every rising clock edge it performs one access. A read/write level picks the kind of access. When the level is high, the addressed word is read into the output register. When it is low, the input word is stored at the addressed location, and the output register keeps the word from the most recent read.

A static mode input picks where the address comes from. In counter mode it comes from an internal free-running counter. The counter steps once per clock and wraps from 2047 back to 0, and a frame pulse pulls it back to 0 so that slot numbering stays aligned to the frame. In external mode the address comes from an 11-bit bus that is sampled on the edge of the access, so any location can be reached in any order.

A typical use is one memory in counter mode that writes each incoming slot in order, paired with another access pattern that reads the slots back in a switched order.

Top module: `slot_mem_top`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the output register and the slot counter are cleared to zero. The first counter-mode access after reset uses location 0. Memory contents are not defined by reset.
- R2: With `rd_wr` = 1 on an edge, the word at the selected address appears on `dout` after that same edge and is valid until the next edge.
- R3: With `rd_wr` = 0 on an edge, the `din` word is stored at the selected address, and a later read of that address returns it.
- R4: On an edge with `rd_wr` = 0, `dout` does not change. It keeps the value of the last read, or zero if no read has happened since reset.
- R5: In counter mode (`mode_ext` = 0), successive accesses use locations 0, 1, 2, … 2047 and then wrap to 0.
- R6: A `frame_pulse` sampled high on an edge loads 0 into the counter on that edge. The access on that edge still uses the old count, and the next access uses location 0. This also holds when the pulse coincides with count 2047.
- R7: In external mode (`mode_ext` = 1), each access uses the `ext_addr` value sampled on its edge.
- R8: A read of a location on the edge right after a write to that same location returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_ext | input | 1 | Address source select: 0 = internal counter, 1 = `ext_addr` |
| frame_pulse | input | 1 | Frame alignment; loads the counter with 0 |
| rd_wr | input | 1 | Access kind: 1 = read, 0 = write |
| ext_addr | input | 11 | Random-access address used in external mode |
| din | input | 16 | Word to store on a write |
| dout | output | 16 | Output register holding the last word read |

## Verification
Two functions can meet on the same edge. A frame pulse can arrive on the access that uses count 2047, so the counter's realignment coincides with its natural wrap. A frame pulse can also arrive mid-frame on a write, so realignment coincides with a store. The bench first fills the memory through the counter with distinct patterns. It then raises the frame pulse at count 2047 and at several mid-frame counts, on both reads and writes. It judges each case by checking that the following reads return the words of locations 0, 1, 2 onward. In external mode, a write followed at once by a read of the same address checks that a store and the next read do not interfere.

// File: rtl/slot_mem_pkg.sv
package slot_mem_pkg;

    localparam int SLOT_ADDR_W = 11;
    localparam int SLOT_DATA_W = 16;

    typedef enum logic {
        SRC_COUNTER  = 1'b0,
        SRC_EXTERNAL = 1'b1
    } addr_src_e;

    typedef struct packed {
        logic                   is_read;
        logic [SLOT_ADDR_W-1:0] addr;
        logic [SLOT_DATA_W-1:0] wdata;
    } slot_access_t;

    function automatic addr_src_e decode_src(input logic sel);
        return sel ? SRC_EXTERNAL : SRC_COUNTER;
    endfunction

endpackage

// File: rtl/slot_counter.sv
module slot_counter #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              align,
    output logic [ADDR_W-1:0] count
);
    // Free-running; natural wrap of the ADDR_W-bit register covers 2^ADDR_W slots.
    always_ff @(posedge clk) begin
        if (rst || align) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/slot_addr_select.sv
module slot_addr_select
    import slot_mem_pkg::*;
(
    input  addr_src_e              src,
    input  logic                   rd_wr,
    input  logic [SLOT_ADDR_W-1:0] cnt_addr,
    input  logic [SLOT_ADDR_W-1:0] bus_addr,
    input  logic [SLOT_DATA_W-1:0] wdata,
    output slot_access_t           acc
);
    always_comb begin
        acc.is_read = rd_wr;
        acc.wdata   = wdata;
        unique case (src)
            SRC_EXTERNAL: acc.addr = bus_addr;
            default:      acc.addr = cnt_addr;
        endcase
    end
endmodule

// File: rtl/slot_array.sv
module slot_array
    import slot_mem_pkg::*;
#(
    parameter int DEPTH = 2048
) (
    input  logic                   clk,
    input  logic                   rst,
    input  slot_access_t           acc,
    output logic [SLOT_DATA_W-1:0] rdata
);
    logic [SLOT_DATA_W-1:0] store [DEPTH];

    // Storage has no reset; writes are suppressed while reset is held.
    always_ff @(posedge clk) begin
        if (!rst && !acc.is_read) begin
            store[acc.addr] <= acc.wdata;
        end
    end

    // Output register only loads on reads, so it holds across writes.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (acc.is_read) begin
            rdata <= store[acc.addr];
        end
    end
endmodule

// File: rtl/slot_mem_top.sv
module slot_mem_top
    import slot_mem_pkg::*;
#(
    parameter int ADDR_W = SLOT_ADDR_W,
    parameter int DATA_W = SLOT_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_ext,
    input  logic              frame_pulse,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [ADDR_W-1:0] cnt_q;
    slot_access_t      acc;

    slot_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .align (frame_pulse),
        .count (cnt_q)
    );

    slot_addr_select u_sel (
        .src      (decode_src(mode_ext)),
        .rd_wr    (rd_wr),
        .cnt_addr (cnt_q),
        .bus_addr (ext_addr),
        .wdata    (din),
        .acc      (acc)
    );

    slot_array #(.DEPTH(DEPTH)) u_arr (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .rdata (dout)
    );
endmodule

// File: rtl/slot_mem_chk.sv
module slot_mem_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_ext,
    input logic              frame_pulse,
    input logic              rd_wr,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic [ADDR_W-1:0] cnt
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (dout == '0 && cnt == '0));

    assert_write_holds_out_R4: assert property (@(posedge clk) disable iff (rst)
        !rd_wr |=> $stable(dout));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        !frame_pulse |=> cnt == ADDR_W'($past(cnt) + 1'b1));

    assert_frame_align_R6: assert property (@(posedge clk) disable iff (rst)
        frame_pulse |=> cnt == '0);

    // R8: back-to-back write then read of one external address
    assert_read_after_write_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_wr && mode_ext && $past(!rst) && $past(!rd_wr) && $past(mode_ext)
         && ext_addr == $past(ext_addr)) |=> dout == $past(din, 2));
endmodule

bind slot_mem_top slot_mem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_ext    (mode_ext),
    .frame_pulse (frame_pulse),
    .rd_wr       (rd_wr),
    .ext_addr    (ext_addr),
    .din         (din),
    .dout        (dout),
    .cnt         (cnt_q)
);

// File: tb/tb_slot_mem_top.sv
`timescale 1ns/1ps
module tb_slot_mem_top;
    localparam int AW = 11;
    localparam int DW = 16;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_ext = 1'b0;
    logic          frame_pulse = 1'b0;
    logic          rd_wr = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference state derived from the requirements
    logic [DW-1:0] ref_mem [N];
    bit            ref_ok  [N];
    logic [AW-1:0] ref_cnt;
    logic [DW-1:0] ref_out;
    bit            ref_out_ok;

    always #2.5 clk = ~clk;

    slot_mem_top dut (
        .clk(clk), .rst(rst), .mode_ext(mode_ext), .frame_pulse(frame_pulse),
        .rd_wr(rd_wr), .ext_addr(ext_addr), .din(din), .dout(dout)
    );

    function automatic logic [DW-1:0] pat(input int i, input int salt);
        return DW'(i * 40503 + salt * 977 + 16'h1a5);
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] exp);
        total++;
        if (dout !== exp) begin
            bad++;
            $display("FAIL %s: dout=%h expected %h", tag, dout, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst = 1'b1; mode_ext = mode; frame_pulse = 1'b0; rd_wr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        ref_cnt = '0; ref_out = '0; ref_out_ok = 1;
        for (int i = 0; i < N; i++) ref_ok[i] = 0;
        check("R1", '0);
    endtask

    // one access; inputs driven at negedge, output sampled at the next negedge
    task automatic step(input logic fp, input logic rw, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string tag);
        logic [AW-1:0] use_a;
        frame_pulse = fp; rd_wr = rw; ext_addr = a; din = d;
        use_a = mode_ext ? a : ref_cnt;
        if (rw) begin
            ref_out = ref_mem[use_a];
            ref_out_ok = ref_ok[use_a];
        end else begin
            ref_mem[use_a] = d;
            ref_ok[use_a] = 1;
        end
        ref_cnt = fp ? '0 : ref_cnt + 1'b1;
        @(negedge clk);
        if (ref_out_ok) check(tag, ref_out);
    endtask

    initial begin
        #(100000 * 5);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: dout=%h expected completion", dout);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5107_c0de));
        // R1 / R5: counter mode starts at 0 after reset, sweeps and wraps
        do_reset(1'b0);
        for (int i = 0; i < N; i++) step(0, 0, '0, pat(i, 1), "R4");
        for (int i = 0; i < N; i++) step(0, 1, '0, '0, "R5");
        // R6: frame pulse mid-frame on a read, then on a write
        for (int i = 0; i < 37; i++) step(0, 1, '0, '0, "R5");
        step(1, 1, '0, '0, "R6");
        for (int i = 0; i < 5; i++) step(0, 1, '0, '0, "R6");
        step(1, 0, '0, 16'hbeef, "R6");
        for (int i = 0; i < 4; i++) step(0, 1, '0, '0, "R6");
        // R6: frame pulse coinciding with count 2047
        while (ref_cnt != AW'(N - 1)) step(0, 1, '0, '0, "R5");
        step(1, 1, '0, '0, "R6");
        for (int i = 0; i < 3; i++) step(0, 1, '0, '0, "R6");
        // R1: reset mid-count realigns to location 0
        do_reset(1'b0);
        step(0, 0, '0, 16'h1234, "R4");
        step(0, 0, '0, 16'h5678, "R4");
        step(1, 1, '0, '0, "R1");
        step(0, 1, '0, '0, "R1");
        step(1, 1, '0, '0, "R1");
        step(0, 1, '0, '0, "R1");
        // external mode: directed corners then random traffic
        do_reset(1'b1);
        step(0, 0, AW'(N - 1), 16'hc0de, "R3");
        step(0, 1, AW'(N - 1), '0, "R8");
        step(0, 0, AW'(0), 16'h0f0f, "R4");
        step(0, 1, AW'(0), '0, "R8");
        step(1, 1, AW'(N - 1), '0, "R7");
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] a;
            a = AW'($urandom % 64);
            step(1'($urandom), 1'($urandom), a, DW'($urandom), "R7");
        end
        for (int i = 0; i < 64; i++) step(0, 1, AW'(i), '0, "R2");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule